// File: doc/BRIEF.md
# Level-Edge Interrupt Capture Unit

This block raises an interrupt request toward a host from one input channel picked out of twenty-four. It merges two kinds of detection. A change of the selected input into its active state is latched, so a pulse that ends before the host responds is still reported. An input that stays active keeps the request up, even after the host tries to clear it.

The host reads the interrupt status from bit 0 of a status byte and clears it with a write strobe. The write carries no data that matters. A polarity input picks which input state counts as active: an input that idles high and triggers on a fall, or one that idles low and triggers on a rise. The request pin is meant for a line shared with other requesters. It therefore comes with an output-enable, which is low whenever interrupts are disabled. The pin levels arrive already synchronized to the clock.

Top module: `irq_level_edge_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status bit is 0 and the request output is 0. Reset also clears a status bit that was set.
- R2: Only the channel whose index equals `chan_sel` (0 to 23) can set the status bit. Activity on any other channel has no effect.
- R3: In the polarity where the selected input idles high (`active_low` = 1), a move of that input to low sets the status bit at the next rising clock edge. In the polarity where it idles low (`active_low` = 0), a move to high does the same.
- R4: An active pulse on the selected input lasting a single clock cycle sets the status bit. The bit stays set after the input returns to idle, until the host clears it.
- R5: A clear strobe while the selected input is idle makes the status bit 0 at the next rising clock edge.
- R6: A clear strobe while the selected input is still active leaves the status bit at 1.
- R7: A clear strobe in the same cycle as a new move into the active state leaves the status bit at 1.
- R8: `status_byte[0]` carries the status bit, and `status_byte[7:1]` always read 0.
- R9: `irq_oe` equals `irq_en`. `irq_req` equals the status bit when `irq_en` = 1 and is 0 when `irq_en` = 0. The status bit is captured whether or not `irq_en` is set.
- R10: A `chan_sel` value of 24 to 31 means no source is selected. The status bit is then never set, whatever the pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| pins | input | 24 | Synchronized channel levels |
| chan_sel | input | 5 | Source channel index; 24 to 31 select no source |
| active_low | input | 1 | 1: idle high, falling change triggers; 0: idle low, rising change triggers |
| irq_en | input | 1 | Enables driving of the shared request line |
| clr_wr | input | 1 | Host write strobe to the status byte; clears the status bit |
| status_byte | output | 8 | Bit 0 is the status bit, other bits 0 |
| irq_req | output | 1 | Request level toward the shared line |
| irq_oe | output | 1 | Output-enable for the request driver |

## Verification
The status bit is one register behind its inputs. A pin change or clear strobe applied before a rising edge shows on `status_byte` and `irq_req` right after that edge. `irq_oe` follows `irq_en` with no delay. The bench drives every stimulus on the falling clock edge and samples on the next falling edge, so each sample sees exactly one register update. It sweeps all 24 channels in both polarities, all eight "no source" codes, and both enable settings.

// File: rtl/irq_level_edge_capture.sv
module irq_level_edge_capture #(
  parameter int NCH = 24,
  parameter int SELW = $clog2(NCH),
  parameter int STW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pins,
  input  logic [SELW-1:0] chan_sel,
  input  logic            active_low,
  input  logic            irq_en,
  input  logic            clr_wr,
  output logic [STW-1:0]  status_byte,
  output logic            irq_req,
  output logic            irq_oe
);

  logic sel_ok, sel_lvl, active, prev_active, edge_hit, is_q;

  always_comb begin
    sel_ok  = 1'b0;
    sel_lvl = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (chan_sel == SELW'(i)) begin
        sel_ok  = 1'b1;
        sel_lvl = pins[i];
      end
    end
  end

  assign active   = sel_ok & (sel_lvl ^ active_low);
  assign edge_hit = active & ~prev_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_active <= 1'b0;
      is_q        <= 1'b0;
    end else begin
      prev_active <= active;
      if (edge_hit)
        is_q <= 1'b1;
      else if (clr_wr)
        is_q <= active;
    end
  end

  assign status_byte = {{(STW-1){1'b0}}, is_q};
  assign irq_oe      = irq_en;
  assign irq_req     = irq_en & is_q;

  a_r4_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !prev_active) |=> status_byte[0]);
  a_r6_level_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && active) |=> status_byte[0]);
  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !active) |=> !status_byte[0]);
  a_r9_no_drive_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);
  a_r10_no_source_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && !status_byte[0]) |=> !status_byte[0]);
  a_r4_holds_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && status_byte[0]) |=> status_byte[0]);

endmodule

// File: tb/irq_level_edge_capture_tb_top.sv
module irq_level_edge_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic [4:0] chan_sel = '0;
  logic active_low = 1'b0;
  logic irq_en = 1'b1;
  logic clr_wr = 1'b0;
  logic [7:0] status_byte;
  logic irq_req, irq_oe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_level_edge_capture dut_i (
    .clk(clk), .rst_n(rst_n), .pins(pins), .chan_sel(chan_sel),
    .active_low(active_low), .irq_en(irq_en), .clr_wr(clr_wr),
    .status_byte(status_byte), .irq_req(irq_req), .irq_oe(irq_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] idle_pins(input logic pol);
    return pol ? 24'hFFFFFF : 24'h000000;
  endfunction

  task automatic clear();
    clr_wr = 1'b1;
    tick();
    clr_wr = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1", status_byte, 8'h00);
    chk("R1", {7'b0, irq_req}, 8'h00);
    tick();
    rst_n = 1'b1;
    chk("R1", status_byte, 8'h00);
    chk("R9", {7'b0, irq_oe}, 8'h01);

    for (int p = 0; p < 2; p++) begin
      active_low = p[0];
      for (int c = 0; c < 24; c++) begin
        int other;
        other = (c + 1) % 24;
        chan_sel = 5'(c);
        pins = idle_pins(active_low);
        tick();
        clear();
        chk("R5", status_byte, 8'h00);
        pins[other] = ~pins[other];
        tick();
        pins[other] = ~pins[other];
        tick();
        chk("R2", status_byte, 8'h00);
        pins[c] = ~pins[c];
        tick();
        pins[c] = ~pins[c];
        chk("R3", status_byte, 8'h01);
        tick();
        chk("R4", status_byte, 8'h01);
        chk("R8", status_byte & 8'hFE, 8'h00);
        clear();
        chk("R5", status_byte, 8'h00);
        pins[c] = ~pins[c];
        tick();
        clear();
        chk("R6", status_byte, 8'h01);
        pins[c] = ~pins[c];
        tick();
        clear();
        chk("R5", status_byte, 8'h00);
      end
    end

    active_low = 1'b0;
    chan_sel = 5'd7;
    pins = '0;
    pins[7] = 1'b1;
    tick();
    pins[7] = 1'b0;
    tick();
    chk("R4", status_byte, 8'h01);
    pins[7] = 1'b1;
    clr_wr = 1'b1;
    tick();
    clr_wr = 1'b0;
    pins[7] = 1'b0;
    chk("R7", status_byte, 8'h01);
    tick();
    chk("R7", status_byte, 8'h01);

    irq_en = 1'b1;
    #1 chk("R9", {6'b0, irq_oe, irq_req}, 8'h03);
    irq_en = 1'b0;
    #1 chk("R9", {6'b0, irq_oe, irq_req}, 8'h00);
    @(negedge clk);
    clear();
    pins[7] = 1'b1;
    tick();
    pins[7] = 1'b0;
    chk("R9", status_byte, 8'h01);
    chk("R9", {6'b0, irq_oe, irq_req}, 8'h00);
    irq_en = 1'b1;
    #1 chk("R9", {7'b0, irq_req}, 8'h01);
    @(negedge clk);

    rst_n = 1'b0;
    #1 chk("R1", status_byte, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1", status_byte, 8'h00);

    for (int s = 24; s < 32; s++) begin
      chan_sel = 5'(s);
      for (int p = 0; p < 2; p++) begin
        active_low = p[0];
        pins = '0;
        tick();
        pins = '1;
        tick();
        pins = '0;
        tick();
        chk("R10", status_byte, 8'h00);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule